// File: doc/BRIEF.md
# Iterative Integer Multiply and Divide Unit

This block performs 32-bit integer multiplication and division, signed or unsigned, one bit per clock. A single-cycle start pulse launches an operation with a two-bit operation code and two operands. The unit raises busy while it works. When it finishes it writes two result registers at once: an upper/remainder register (HI) and a lower/quotient register (LO). It then pulses done for one cycle.

Software-visible results are never returned directly. Two read requests copy HI or LO onto a registered read bus one cycle later. A read made while the unit is busy is held off: the stall output is raised and no valid data is returned, so the requester retries until busy is low.

Magnitudes are processed by a shift-add multiplier and a restoring divider that share one working register pair. Signs are applied in a final cycle. No operation ever flags overflow.

Top module: `muldiv_unit`

## Requirements
- R1: Operation code 0 is a signed multiply. The 64-bit two's-complement product goes with its upper half to HI and its lower half to LO.
- R2: Operation code 1 is an unsigned multiply. The 64-bit product is split the same way as in R1.
- R3: Operation code 2 is a signed divide. LO receives the quotient truncated toward zero, and HI receives the remainder, which carries the sign of the dividend.
- R4: Operation code 3 is an unsigned divide. LO receives the unsigned quotient and HI the unsigned remainder.
- R5: A divide by zero, signed or unsigned, completes normally. LO becomes 32'hFFFFFFFF and HI becomes the dividend unchanged.
- R6: A start accepted at a clock edge raises busy in the next cycle. Busy stays high for exactly 33 cycles. HI and LO change only at the edge where busy falls, and done is high for exactly the one cycle after that edge.
- R7: A start pulse while busy is high is ignored. The running operation's results and timing are unchanged, and no further operation runs.
- R8: A read request while busy is low loads rd_data in the next cycle with rd_valid high. rd_hi selects HI and rd_lo selects LO, and rd_hi wins if both are high.
- R9: A read request while busy is high drives rd_stall high in the same cycle, and rd_valid stays low in the next cycle.
- R10: After reset, busy, done and rd_valid are low and both HI and LO read as zero.
- R11: Signed divide of 32'h80000000 by 32'hFFFFFFFF wraps without any signal: LO is 32'h80000000 and HI is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation (ignored while busy) |
| op | input | 2 | 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div |
| opnd_a | input | 32 | Multiplicand or dividend |
| opnd_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when HI/LO are written |
| rd_hi | input | 1 | Request a copy of HI |
| rd_lo | input | 1 | Request a copy of LO |
| rd_stall | output | 1 | Read request refused because the unit is busy |
| rd_valid | output | 1 | rd_data holds the value requested in the previous cycle |
| rd_data | output | 32 | Copy of HI or LO |

## Verification
Counting from the edge that accepts start, busy is high from the next cycle for 33 cycles, and done and the new HI/LO appear 33 edges later. A read result follows its request by one edge. The bench drives every input on the falling edge and counts falling edges from the start. It requires done to appear on the 34th of those falling edges and samples rd_data on the falling edge after each request. A stall is checked within the same half cycle the request is raised, and the refused read is checked one edge later.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MUL_S = 2'd0,
    OP_MUL_U = 2'd1,
    OP_DIV_S = 2'd2,
    OP_DIV_U = 2'd3
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } md_state_e;
endpackage

// File: rtl/md_mul_step.sv
// One shift-add multiply iteration: the low word holds the remaining multiplier bits
// and collects product bits as the accumulator shifts right.
module md_mul_step #(
  parameter int W = 32
) (
  input  logic [W:0]   acc_hi,
  input  logic [W-1:0] acc_lo,
  input  logic [W-1:0] mcand,
  output logic [W:0]   nxt_hi,
  output logic [W-1:0] nxt_lo
);
  logic [W:0] sum;

  always_comb begin
    sum    = acc_lo[0] ? (acc_hi + {1'b0, mcand}) : acc_hi;
    nxt_hi = {1'b0, sum[W:1]};
    nxt_lo = {sum[0], acc_lo[W-1:1]};
  end
endmodule

// File: rtl/md_div_step.sv
// One restoring divide iteration: shift in the next dividend bit, try the subtraction,
// keep the difference only when it is not negative.
module md_div_step #(
  parameter int W = 32
) (
  input  logic [W:0]   rem,
  input  logic [W-1:0] quo,
  input  logic [W-1:0] dvsr,
  output logic [W:0]   nxt_rem,
  output logic [W-1:0] nxt_quo
);
  logic [W:0]   shifted;
  logic [W+1:0] trial;

  always_comb begin
    shifted = {rem[W-1:0], quo[W-1]};
    trial   = {1'b0, shifted} - {2'b00, dvsr};
    if (!trial[W+1]) begin
      nxt_rem = trial[W:0];
      nxt_quo = {quo[W-2:0], 1'b1};
    end else begin
      nxt_rem = shifted;
      nxt_quo = {quo[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         busy,
  output logic         done,
  input  logic         rd_hi,
  input  logic         rd_lo,
  output logic         rd_stall,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  localparam int CW  = $clog2(W);
  localparam int RES = 2 * W;
  localparam int LAT = W + 1;
  localparam int LCW = $clog2(LAT + 2);

  md_state_e    state;
  logic [CW-1:0] cnt;
  logic [W:0]   work_hi;
  logic [W-1:0] work_lo;
  logic [W-1:0] oper_b;
  logic [W-1:0] dvd_keep;
  logic         is_div, neg_q, neg_r, div_zero;
  logic [W-1:0] hi_r, lo_r;
  logic         done_r;
  logic [W-1:0] rd_data_r;
  logic         rd_valid_r;

  // operand magnitudes for the start cycle
  logic         sgn_op, a_neg, b_neg;
  logic [W-1:0] a_mag, b_mag;
  always_comb begin
    sgn_op = ~op[0];
    a_neg  = sgn_op & opnd_a[W-1];
    b_neg  = sgn_op & opnd_b[W-1];
    a_mag  = a_neg ? (~opnd_a + 1'b1) : opnd_a;
    b_mag  = b_neg ? (~opnd_b + 1'b1) : opnd_b;
  end

  // iteration datapaths
  logic [W:0]   mul_hi, div_hi;
  logic [W-1:0] mul_lo, div_lo;

  md_mul_step #(.W(W)) u_mul (
    .acc_hi(work_hi), .acc_lo(work_lo), .mcand(oper_b),
    .nxt_hi(mul_hi),  .nxt_lo(mul_lo)
  );

  md_div_step #(.W(W)) u_div (
    .rem(work_hi),    .quo(work_lo), .dvsr(oper_b),
    .nxt_rem(div_hi), .nxt_quo(div_lo)
  );

  // sign fix-up for the final cycle
  logic [RES-1:0] prod;
  logic [W-1:0]   fin_hi, fin_lo;
  always_comb begin
    prod = {work_hi[W-1:0], work_lo};
    if (neg_q && !is_div) prod = ~prod + 1'b1;
    if (!is_div) begin
      fin_hi = prod[RES-1:W];
      fin_lo = prod[W-1:0];
    end else if (div_zero) begin
      fin_hi = dvd_keep;
      fin_lo = '1;
    end else begin
      fin_lo = neg_q ? (~work_lo + 1'b1) : work_lo;
      fin_hi = neg_r ? (~work_hi[W-1:0] + 1'b1) : work_hi[W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      work_hi  <= '0;
      work_lo  <= '0;
      oper_b   <= '0;
      dvd_keep <= '0;
      is_div   <= 1'b0;
      neg_q    <= 1'b0;
      neg_r    <= 1'b0;
      div_zero <= 1'b0;
      hi_r     <= '0;
      lo_r     <= '0;
      done_r   <= 1'b0;
    end else begin
      done_r <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state    <= ST_RUN;
          cnt      <= '0;
          work_hi  <= '0;
          work_lo  <= a_mag;
          oper_b   <= b_mag;
          dvd_keep <= opnd_a;
          is_div   <= op[1];
          neg_q    <= a_neg ^ b_neg;
          neg_r    <= a_neg;
          div_zero <= op[1] & (opnd_b == '0);
        end
        ST_RUN: begin
          work_hi <= is_div ? div_hi : mul_hi;
          work_lo <= is_div ? div_lo : mul_lo;
          cnt     <= cnt + 1'b1;
          if (cnt == CW'(W - 1)) state <= ST_FIN;
        end
        ST_FIN: begin
          hi_r   <= fin_hi;
          lo_r   <= fin_lo;
          done_r <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // read ports: refused while an operation is in flight
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_r  <= '0;
      rd_valid_r <= 1'b0;
    end else begin
      rd_valid_r <= (rd_hi | rd_lo) & (state == ST_IDLE);
      if ((rd_hi | rd_lo) && state == ST_IDLE)
        rd_data_r <= rd_hi ? hi_r : lo_r;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = done_r;
  assign rd_stall = (rd_hi | rd_lo) & busy;
  assign rd_valid = rd_valid_r;
  assign rd_data  = rd_data_r;

  // ---------------- assertions ----------------
  logic [LCW-1:0] busy_len;
  always_ff @(posedge clk) begin
    if (rst)       busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  p_busy_len_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_len == LCW'(LAT)));
  p_hilo_hold_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($stable(hi_r) && $stable(lo_r)));
  p_busy_from_start_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  p_no_read_busy_r9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !$past(busy));
  p_rem_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && is_div && !div_zero) |-> (work_hi < {1'b0, oper_b}));
endmodule

// File: tb/sim_muldiv_unit.sv
`timescale 1ns/1ps
module sim_muldiv_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        busy, done, rd_hi = 1'b0, rd_lo = 1'b0, rd_stall, rd_valid;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  muldiv_unit u0 (
    .clk(clk), .rst(rst), .start(start), .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .busy(busy), .done(done), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .rd_stall(rd_stall), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // {op, a, b, expected HI, expected LO}
  localparam int NV = 11;
  localparam logic [129:0] VEC [NV] = '{
    {2'd0, 32'hFFFFFFFD, 32'h00000007, 32'hFFFFFFFF, 32'hFFFFFFEB}, // R1 -3*7
    {2'd0, 32'h00010000, 32'h00010000, 32'h00000001, 32'h00000000}, // R1 carry into HI
    {2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h00000001}, // R1 -1*-1
    {2'd0, 32'h80000000, 32'h80000000, 32'h40000000, 32'h00000000}, // R1 min*min
    {2'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h00000001}, // R2 max*max
    {2'd1, 32'h12345678, 32'h00000010, 32'h00000001, 32'h23456780}, // R2
    {2'd2, 32'hFFFFFFF9, 32'h00000002, 32'hFFFFFFFF, 32'hFFFFFFFD}, // R3 -7/2
    {2'd2, 32'h00000007, 32'hFFFFFFFE, 32'h00000001, 32'hFFFFFFFD}, // R3 7/-2
    {2'd2, 32'hFFFFFFF9, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'h00000003}, // R3 -7/-2
    {2'd3, 32'hFFFFFFF9, 32'h00000002, 32'h00000001, 32'h7FFFFFFC}, // R4
    {2'd3, 32'h00000064, 32'h00000007, 32'h00000002, 32'h0000000E}  // R4 100/7
  };

  function automatic string op_tag(input logic [1:0] o);
    case (o)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called on a falling edge; returns on the falling edge where done is seen
  task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                        output int lat, output logic busy1);
    start = 1'b1; op = o; opnd_a = a; opnd_b = b;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    busy1 = busy;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  // called on a falling edge; returns one falling edge later with the data
  task automatic read_reg(input logic sel_hi, output logic [31:0] d, output logic v);
    rd_hi = sel_hi; rd_lo = ~sel_hi;
    @(negedge clk);
    d = rd_data; v = rd_valid;
    rd_hi = 1'b0; rd_lo = 1'b0;
  endtask

  task automatic op_and_check(input string tag, input logic [1:0] o, input logic [31:0] a,
                              input logic [31:0] b, input logic [31:0] eh, input logic [31:0] el);
    int lat; logic b1; logic [31:0] d; logic v;
    run_op(o, a, b, lat, b1);
    chk({tag, " latency"}, lat, 34);
    read_reg(1'b1, d, v);
    chk({tag, " HI"}, d, eh);
    read_reg(1'b0, d, v);
    chk({tag, " LO"}, d, el);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog R6: actual %0d cycles expected under 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat; logic b1; logic [31:0] d; logic v; logic extra;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 rd_valid", rd_valid, 0);
    read_reg(1'b1, d, v);
    chk("R10 HI", d, 0);
    read_reg(1'b0, d, v);
    chk("R10 LO", d, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      op_and_check(op_tag(VEC[i][129:128]), VEC[i][129:128], VEC[i][127:96],
                   VEC[i][95:64], VEC[i][63:32], VEC[i][31:0]);
    end

    // R5 divide by zero, both flavours
    op_and_check("R5 signed", 2'd2, 32'hFFFFFFF9, 32'h0, 32'hFFFFFFF9, 32'hFFFFFFFF);
    op_and_check("R5 unsigned", 2'd3, 32'h00001234, 32'h0, 32'h00001234, 32'hFFFFFFFF);

    // R11 wrap with no signal
    op_and_check("R11", 2'd2, 32'h80000000, 32'hFFFFFFFF, 32'h00000000, 32'h80000000);

    // R6 busy onset and one-cycle done
    run_op(2'd1, 32'd3, 32'd4, lat, b1);
    chk("R6 busy after start", b1, 1);
    chk("R6 busy low at done", busy, 0);
    @(negedge clk);
    chk("R6 done one cycle", done, 0);

    // R7 start while busy ignored
    start = 1'b1; op = 2'd0; opnd_a = 32'd5; opnd_b = 32'd6;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    repeat (4) begin @(negedge clk); lat++; end
    start = 1'b1; op = 2'd3; opnd_a = 32'd100; opnd_b = 32'd7;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    chk("R7 latency", lat, 34);
    read_reg(1'b1, d, v);
    chk("R7 HI", d, 0);
    read_reg(1'b0, d, v);
    chk("R7 LO", d, 30);
    extra = 1'b0;
    repeat (40) begin @(negedge clk); if (busy || done) extra = 1'b1; end
    chk("R7 no second run", extra, 0);

    // R9 read while busy
    start = 1'b1; op = 2'd0; opnd_a = 32'd9; opnd_b = 32'd9;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rd_lo = 1'b1;
    #1;
    chk("R9 stall", rd_stall, 1);
    @(negedge clk);
    chk("R9 no valid", rd_valid, 0);
    rd_lo = 1'b0;
    while (!done) @(negedge clk);

    // R8 both requests: HI wins, valid set
    rd_hi = 1'b1; rd_lo = 1'b1;
    @(negedge clk);
    rd_hi = 1'b0; rd_lo = 1'b0;
    chk("R8 valid", rd_valid, 1);
    chk("R8 HI priority", rd_data, 0);
    read_reg(1'b0, d, v);
    chk("R8 LO", d, 81);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule